// File: doc/BRIEF.md
# Composite Video Raster Timing Generator

This block generates the raster timing for a monochrome composite video signal. It is clocked at one tick per 0.1 µs. Two digital outputs feed an external resistor network. The level bit `sync_lvl` selects between the 0 V sync level (low) and the 0.3 V blank level (high). The picture bit `pix` raises the signal to white. Each line is 635 ticks long.

A frame has 242 picture lines followed by 20 vertical-sync lines. On each picture line the block reads 32 bytes from an external buffer through a request/address port and serialises them into a 256-pixel window. Bits leave least significant first and each pixel lasts two ticks. The buffer answers a request on the next clock edge. The fetch address starts at 0 on every frame and advances by one per request.

All outputs are decoded from registered counters in the same tick. The one exception is the first pixel of each byte: it is taken straight from `rd_data` in the tick after the request, and the byte is captured into the shifter at the end of that tick. After reset the block sits at tick 0 of the first picture line. `rst_n` is asserted asynchronously and is expected to be released away from the rising clock edge.

Top module: `composite_raster_gen`

## Requirements
- R1: A line lasts exactly 635 ticks, and `line_start` is high only in its tick 0.
- R2: On a picture line `sync_lvl` is 0 for ticks 0..46 and 1 for ticks 47..634.
- R3: `pix` is 0 outside ticks 106..617 of a picture line, and it is 0 on every vertical-sync line.
- R4: Byte b of a line covers ticks 106+16b..121+16b. Its bit k (k = 0 is the least significant bit) is on `pix` during ticks 106+16b+2k and 107+16b+2k.
- R5: `rd_req` is high for one tick at tick 105+16b of a picture line, for b = 0..31, and at no other time. `rd_data` is sampled on the rising edge that ends the following tick.
- R6: The address given with the request for byte b of picture line n (n from 0) is 32n+b. Addressing restarts at 0 each frame.
- R7: Lines 0..241 of a frame are picture lines and lines 242..261 are vertical-sync lines. `vblank` is 1 exactly on the vertical-sync lines.
- R8: On a vertical-sync line `sync_lvl` is 1 for ticks 0..46 and 0 for ticks 47..634.
- R9: After tick 634 of line 261 the next tick is tick 0 of line 0, with no gap. `frame_start` is high only in tick 0 of line 0.
- R10: While `rst_n` is low the block holds tick 0 of line 0: `sync_lvl`=0, `pix`=0, `rd_req`=0, `vblank`=0, and `line_start`=`frame_start`=1. Counting resumes from there after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one cycle per 0.1 µs |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | output | 1 | Byte fetch strobe |
| rd_addr | output | 13 | Fetch address, valid while `rd_req` is high |
| rd_data | input | 8 | Fetched byte, valid in the tick after `rd_req` |
| sync_lvl | output | 1 | 0 = sync level, 1 = blank level |
| pix | output | 1 | White pixel bit |
| line_start | output | 1 | High in tick 0 of each line |
| frame_start | output | 1 | High in tick 0 of line 0 |
| vblank | output | 1 | High on vertical-sync lines |

## Verification
Every level output is a decode of the tick and line counters, so its expected value is due in the same tick as the counter position it depends on. The bench keeps its own tick count, starting at 0 on the falling edge where reset is released, and compares all outputs at each falling edge against values computed from that count. Fetched data appears one rising edge after the request, and the first pixel of a byte is due in that same following tick. The bench's buffer model answers on the edge that ends the request tick, and its pixel expectation is placed on tick 106+16b. An asynchronous reset takes effect at once, so it is checked one time step after the drop.

// File: rtl/vid_pkg.sv
package vid_pkg;
  // kind of raster line currently being produced
  typedef enum logic {
    LN_PICTURE = 1'b0,
    LN_VSYNC   = 1'b1
  } line_kind_e;
endpackage

// File: rtl/vid_line_timer.sv
module vid_line_timer
  import vid_pkg::*;
#(
  parameter int LINE_TICKS     = 635,
  parameter int HSYNC_TICKS    = 47,
  parameter int VS_BLANK_TICKS = 47,
  parameter int ACTIVE_LINES   = 242,
  parameter int VSYNC_LINES    = 20,
  localparam int TOTAL_LINES   = ACTIVE_LINES + VSYNC_LINES,
  localparam int H_W           = $clog2(LINE_TICKS),
  localparam int L_W           = $clog2(TOTAL_LINES)
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic [H_W-1:0] hcnt,
  output line_kind_e     kind,
  output logic           line_start,
  output logic           frame_start,
  output logic           sync_lvl
);
  localparam logic [H_W-1:0] LAST_H   = H_W'(LINE_TICKS - 1);
  localparam logic [H_W-1:0] HSYNC_H  = H_W'(HSYNC_TICKS);
  localparam logic [H_W-1:0] VSBLK_H  = H_W'(VS_BLANK_TICKS);
  localparam logic [L_W-1:0] LAST_L   = L_W'(TOTAL_LINES - 1);
  localparam logic [L_W-1:0] ACTIVE_L = L_W'(ACTIVE_LINES);

  logic [H_W-1:0] hcnt_q, hcnt_d;
  logic [L_W-1:0] lcnt_q, lcnt_d;
  logic           line_end, lcnt_en;

  // next state
  always_comb begin
    line_end = (hcnt_q == LAST_H);
    hcnt_d   = line_end ? '0 : hcnt_q + H_W'(1);
    lcnt_en  = line_end;
    lcnt_d   = (lcnt_q == LAST_L) ? '0 : lcnt_q + L_W'(1);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      lcnt_q <= '0;
    end else begin
      hcnt_q <= hcnt_d;
      if (lcnt_en) lcnt_q <= lcnt_d;
    end
  end

  // decode
  always_comb begin
    hcnt        = hcnt_q;
    kind        = (lcnt_q < ACTIVE_L) ? LN_PICTURE : LN_VSYNC;
    line_start  = (hcnt_q == '0);
    frame_start = (hcnt_q == '0) && (lcnt_q == '0);
    if (kind == LN_PICTURE) sync_lvl = (hcnt_q >= HSYNC_H);
    else                    sync_lvl = (hcnt_q <  VSBLK_H);
  end

  // R1
  hcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt_q <= LAST_H);

  // R9
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lcnt_q == LAST_L && hcnt_q == LAST_H) |=> (lcnt_q == '0 && hcnt_q == '0));
endmodule

// File: rtl/vid_fetch.sv
module vid_fetch
  import vid_pkg::*;
#(
  parameter int H_W            = 10,
  parameter int ADDR_W         = 13,
  parameter int PIX_START      = 106,
  parameter int BYTES_PER_LINE = 32,
  parameter int GROUP_TICKS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [H_W-1:0]    hcnt,
  input  line_kind_e        kind,
  input  logic              frame_start,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr
);
  localparam logic [H_W-1:0] FIRST_H = H_W'(PIX_START - 1);
  localparam logic [H_W-1:0] LAST_H  = H_W'(PIX_START - 1 + (BYTES_PER_LINE - 1) * GROUP_TICKS);
  localparam logic [H_W-1:0] GROUP_H = H_W'(GROUP_TICKS);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [H_W-1:0]    off;
  logic              addr_en;

  always_comb begin
    off     = hcnt - FIRST_H;
    rd_req  = (kind == LN_PICTURE) && (hcnt >= FIRST_H) && (hcnt <= LAST_H)
              && ((off % GROUP_H) == '0);
    addr_en = rd_req || frame_start;
    addr_d  = frame_start ? '0 : addr_q + ADDR_W'(1);
    rd_addr = addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  // R5
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> (addr_q == $past(addr_q) + ADDR_W'(1)));
endmodule

// File: rtl/vid_shifter.sv
module vid_shifter
  import vid_pkg::*;
#(
  parameter int H_W            = 10,
  parameter int DATA_W         = 8,
  parameter int PIX_START      = 106,
  parameter int BYTES_PER_LINE = 32,
  parameter int PIX_TICKS      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [H_W-1:0]    hcnt,
  input  line_kind_e        kind,
  input  logic [DATA_W-1:0] rd_data,
  output logic              pix
);
  localparam int             GROUP_TICKS = DATA_W * PIX_TICKS;
  localparam logic [H_W-1:0] START_H = H_W'(PIX_START);
  localparam logic [H_W-1:0] END_H   = H_W'(PIX_START + BYTES_PER_LINE * GROUP_TICKS);
  localparam logic [H_W-1:0] GROUP_H = H_W'(GROUP_TICKS);
  localparam logic [H_W-1:0] PIX_H   = H_W'(PIX_TICKS);

  logic [DATA_W-1:0] sh_q, sh_d, base;
  logic [H_W-1:0]    off;
  logic              win, load, rot, sh_en;

  always_comb begin
    win   = (kind == LN_PICTURE) && (hcnt >= START_H) && (hcnt < END_H);
    off   = hcnt - START_H;
    load  = win && ((off % GROUP_H) == '0);
    rot   = win && ((off % PIX_H) == (PIX_H - H_W'(1)));
    sh_en = load || rot;
    base  = load ? rd_data : sh_q;
    sh_d  = rot ? {base[0], base[DATA_W-1:1]} : base;
    pix   = win && (load ? rd_data[0] : sh_q[0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end
endmodule

// File: rtl/composite_raster_gen.sv
module composite_raster_gen
  import vid_pkg::*;
#(
  parameter int LINE_TICKS     = 635,
  parameter int HSYNC_TICKS    = 47,
  parameter int VS_BLANK_TICKS = 47,
  parameter int PIX_START      = 106,
  parameter int BYTES_PER_LINE = 32,
  parameter int DATA_W         = 8,
  parameter int PIX_TICKS      = 2,
  parameter int ACTIVE_LINES   = 242,
  parameter int VSYNC_LINES    = 20,
  localparam int H_W           = $clog2(LINE_TICKS),
  localparam int ADDR_W        = $clog2(ACTIVE_LINES * BYTES_PER_LINE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              sync_lvl,
  output logic              pix,
  output logic              line_start,
  output logic              frame_start,
  output logic              vblank
);
  logic [H_W-1:0] hcnt;
  line_kind_e     kind;

  vid_line_timer #(
    .LINE_TICKS(LINE_TICKS), .HSYNC_TICKS(HSYNC_TICKS),
    .VS_BLANK_TICKS(VS_BLANK_TICKS), .ACTIVE_LINES(ACTIVE_LINES),
    .VSYNC_LINES(VSYNC_LINES)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .kind(kind),
    .line_start(line_start), .frame_start(frame_start), .sync_lvl(sync_lvl)
  );

  vid_fetch #(
    .H_W(H_W), .ADDR_W(ADDR_W), .PIX_START(PIX_START),
    .BYTES_PER_LINE(BYTES_PER_LINE), .GROUP_TICKS(DATA_W * PIX_TICKS)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .kind(kind),
    .frame_start(frame_start), .rd_req(rd_req), .rd_addr(rd_addr)
  );

  vid_shifter #(
    .H_W(H_W), .DATA_W(DATA_W), .PIX_START(PIX_START),
    .BYTES_PER_LINE(BYTES_PER_LINE), .PIX_TICKS(PIX_TICKS)
  ) u_shift (
    .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .kind(kind),
    .rd_data(rd_data), .pix(pix)
  );

  assign vblank = (kind == LN_VSYNC);

  // R3
  vblank_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vblank |-> !pix);

  // R8
  vs_line_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank && line_start) |-> sync_lvl);

  // R7
  vs_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vblank |-> !rd_req);
endmodule

// File: tb/tb_composite_raster_gen.sv
`timescale 1ns/1ps
module tb_composite_raster_gen;
  localparam int LT    = 635;
  localparam int NL    = 262;
  localparam int FRAME = LT * NL;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_req;
  logic [12:0] rd_addr;
  logic [7:0]  rd_data = '0;
  logic        sync_lvl, pix, line_start, frame_start, vblank;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  composite_raster_gen dut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_data(rd_data), .sync_lvl(sync_lvl), .pix(pix),
    .line_start(line_start), .frame_start(frame_start), .vblank(vblank)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 29) ^ (a >> 4) ^ 8'h5A);
  endfunction

  // buffer model: answers a request on the edge that ends the request tick
  always @(posedge clk) if (rd_req) rd_data <= pat(int'(rd_addr));

  task automatic chk(input int act, input int exp, input string req);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected behaviour at tick t counted from reset release
  task automatic check_tick(input int t);
    int tt, l, h, b, k;
    int e_sync, e_req, e_pix;
    tt = t % FRAME;
    l  = tt / LT;
    h  = tt % LT;
    e_sync = (l < 242) ? int'(h >= 47) : int'(h < 47);
    e_req  = int'(l < 242 && h >= 105 && h <= 601 && ((h - 105) % 16) == 0);
    e_pix  = 0;
    if (l < 242 && h >= 106 && h < 618) begin
      b = (h - 106) / 16;
      k = ((h - 106) / 2) % 8;
      e_pix = int'(pat(l * 32 + b) >> k) & 1;
    end
    chk(int'(line_start), int'(h == 0), "R1 line_start");
    chk(int'(sync_lvl), e_sync, (l < 242) ? "R2 picture sync" : "R8 vsync level");
    chk(int'(pix), e_pix, (l < 242 && h >= 106 && h < 618) ? "R4 pixel bit" : "R3 dark");
    chk(int'(rd_req), e_req, "R5 request");
    if (e_req != 0) chk(int'(rd_addr), l * 32 + (h - 105) / 16, "R6 address");
    chk(int'(vblank), int'(l >= 242), "R7 vblank");
    chk(int'(frame_start), int'(tt == 0), "R9 frame_start");
  endtask

  // vectors: line, tick, sync_lvl, vblank, rd_req, requirement number
  localparam int NV = 15;
  localparam int VEC [NV][6] = '{
    '{0,   0,   0, 0, 0, 2},
    '{0,   46,  0, 0, 0, 2},
    '{0,   47,  1, 0, 0, 2},
    '{0,   104, 1, 0, 0, 5},
    '{0,   105, 1, 0, 1, 5},
    '{0,   106, 1, 0, 0, 5},
    '{0,   601, 1, 0, 1, 5},
    '{0,   617, 1, 0, 0, 3},
    '{0,   634, 1, 0, 0, 1},
    '{241, 634, 1, 0, 0, 7},
    '{242, 0,   1, 1, 0, 8},
    '{242, 46,  1, 1, 0, 8},
    '{242, 47,  0, 1, 0, 8},
    '{261, 634, 0, 1, 0, 9},
    '{262, 0,   0, 0, 0, 9}
  };

  initial begin
    int vi;
    // R10: reset state while held
    repeat (3) @(negedge clk);
    chk(int'(sync_lvl), 0, "R10 reset sync_lvl");
    chk(int'(pix), 0, "R10 reset pix");
    chk(int'(frame_start), 1, "R10 reset frame_start");
    chk(int'(rd_req), 0, "R10 reset rd_req");
    chk(int'(vblank), 0, "R10 reset vblank");
    rst_n = 1'b1;

    // one full frame plus a little of the next; vector table walked alongside
    vi = 0;
    for (int t = 0; t < FRAME + LT + 300; t++) begin
      check_tick(t);
      if (vi < NV && t == VEC[vi][0] * LT + VEC[vi][1]) begin
        chk(int'(sync_lvl), VEC[vi][2], $sformatf("R%0d vector %0d sync", VEC[vi][5], vi));
        chk(int'(vblank),   VEC[vi][3], $sformatf("R%0d vector %0d vblank", VEC[vi][5], vi));
        chk(int'(rd_req),   VEC[vi][4], $sformatf("R%0d vector %0d req", VEC[vi][5], vi));
        vi++;
      end
      @(negedge clk);
    end
    chk(vi, NV, "R9 vector walk complete");

    // R10: mid-frame reset returns to tick 0 of line 0
    rst_n = 1'b0;
    #1;
    chk(int'(line_start), 1, "R10 midrun line_start");
    chk(int'(frame_start), 1, "R10 midrun frame_start");
    chk(int'(sync_lvl), 0, "R10 midrun sync_lvl");
    chk(int'(pix), 0, "R10 midrun pix");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int t = 0; t < LT + 80; t++) begin
      check_tick(t);
      @(negedge clk);
    end

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule